// File: doc/BRIEF.md
# Phase Accumulator with Auxiliary Accumulator

This block is the numeric core of a direct digital synthesizer. A phase accumulator adds a frequency tuning word to itself on every clock. The registered result, plus a phase offset, is presented as the phase word for a downstream amplitude stage. A second, auxiliary accumulator can play one of two roles. In the first role it runs a linear frequency ramp whose value is added to the tuning word. In the second role it is a fractional numerator/denominator counter, and its wrap carries an extra count into the phase accumulator.

A divider makes a slow sync tick, once every `SYNC_DIV` clocks. The sweep ramp advances on that tick, and a change to the auxiliary clear setting takes effect on it. A clear request is captured on an update strobe or on a change of the active profile. It then becomes active at the next sync tick. The active profile comes either from external pins or from an internal field.

The phase accumulator has a clear of its own that acts at once. A latency selector decides whether the phase offset is delayed to line up with the accumulated tuning word, or is applied with one stage less delay.

Top module: `dds_phase_core`

## Requirements
- R1: During reset, `phase_out` is 0 and `sync_tick` is 0. After reset is released, both accumulators start from 0.
- R2: With the auxiliary path idle, the accumulator grows by `ftw` on every clock, modulo 2^PW. `phase_out` at the edge after cycle t equals acc(t) plus the offset.
- R3: While `clr_phase` is 1, the accumulator is loaded with 0 at every edge. Accumulation resumes from 0 on the first edge after `clr_phase` returns to 0.
- R4: Sweep mode is active when `sweep_en`=1, `modulus_en`=0 and `dsw_en`=0. In sweep mode the auxiliary value rises by `sweep_step` on each sync tick and saturates at `sweep_limit`. Between ticks it is stable. Its current value is added to `ftw` at every phase step.
- R5: Modulus mode is active when `sweep_en`=1, `modulus_en`=1 and `dsw_en`=0. In modulus mode the auxiliary value adds `mod_num` on every clock. When the sum is at least `mod_den`, `mod_den` is subtracted and one extra count enters the phase accumulator.
- R6: When `sweep_en`=0, `modulus_en` has no effect. The phase grows by `ftw` alone.
- R7: `clr_aux` is sampled when `upd_strobe`=1 or when the active profile differs from its value in the previous cycle. The sampled value becomes the active auxiliary clear at the next sync tick, including a tick in the same cycle. While that clear is active, the auxiliary value is 0.
- R8: `active_prof` equals `prof_int` when `prof_from_int`=1, and `prof_pins` when it is 0.
- R9: With `lat_unmatched`=0, `pow` reaches `phase_out` two edges after it is applied. With `lat_unmatched`=1, it arrives one edge after. The accumulator term is one edge in both cases.
- R10: With `dsw_en`=1, the auxiliary value holds and contributes nothing to the phase.
- R11: `sync_tick` is 1 for exactly one clock in every `SYNC_DIV` clocks. The first tick comes in the `SYNC_DIV`-th cycle after reset, when the divider count is `SYNC_DIV`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_strobe | input | 1 | Update strobe that samples the auxiliary clear request |
| sweep_en | input | 1 | Enables the auxiliary path |
| modulus_en | input | 1 | Selects the modulus role (1) or the sweep role (0) |
| dsw_en | input | 1 | Direct switch mode; bypasses the auxiliary path |
| prof_from_int | input | 1 | Profile source: 1 internal field, 0 pins |
| prof_int | input | PROF_W | Internal profile field |
| prof_pins | input | PROF_W | External profile pins |
| clr_phase | input | 1 | Static clear of the phase accumulator |
| clr_aux | input | 1 | Requested auxiliary clear (synchronized) |
| lat_unmatched | input | 1 | 0 equalizes the offset latency, 1 shortens it |
| ftw | input | PW | Frequency tuning word |
| pow | input | PW | Phase offset word |
| sweep_step | input | AUX_W | Ramp increment per sync tick |
| sweep_limit | input | AUX_W | Ramp ceiling |
| mod_num | input | AUX_W | Modulus numerator step |
| mod_den | input | AUX_W | Modulus denominator |
| phase_out | output | PW | Phase word |
| sync_tick | output | 1 | Divided sync pulse |
| active_prof | output | PROF_W | Currently selected profile |

## Verification
The tuning word is tried with a small value and with a value near full scale. These show ordinary growth and the wrap modulo 2^32. The offset is stepped every cycle under both latency settings, so a one-cycle shift in its alignment shows up directly in the phase word. The sweep runs long enough to reach and hold its ceiling, which separates the per-tick stepping from the saturation.

A clear request that arrives without an event must leave the ramp running. The same request, once it is sampled by an update or by a profile switch, stops the ramp at the next tick. A small numerator over denominator (3/7) yields a periodic pattern of carries. The modulus case is also run with the sweep enable off, and with the auxiliary path bypassed, to show that the auxiliary contribution disappears in both.

// File: rtl/dds_core_pkg.sv
package dds_core_pkg;

  // Role played by the auxiliary accumulator
  typedef enum logic [1:0] {
    AUX_IDLE  = 2'd0,
    AUX_SWEEP = 2'd1,
    AUX_MOD   = 2'd2
  } aux_mode_e;

  // The modulus choice only matters when the auxiliary path is enabled.
  // Direct switch mode bypasses the path entirely.
  function automatic aux_mode_e pick_aux_mode(input logic en,
                                              input logic modulus,
                                              input logic dsw);
    if (!en || dsw) return AUX_IDLE;
    return modulus ? AUX_MOD : AUX_SWEEP;
  endfunction

endpackage

// File: rtl/dds_sync_div.sv
module dds_sync_div #(
  parameter int SYNC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= '0;
    else          cnt <= cnt + CW'(1);
  end

  // R11
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dds_aux_clr_sync.sv
module dds_aux_clr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic prof_chg,
  input  logic tick,
  input  logic clr_req,
  output logic clr_active
);
  logic pend;
  logic pend_val;
  logic sample_ev;

  assign sample_ev = upd | prof_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_val   <= 1'b0;
      clr_active <= 1'b0;
    end else if (tick && (sample_ev || pend)) begin
      clr_active <= sample_ev ? clr_req : pend_val;
      pend       <= 1'b0;
    end else if (sample_ev) begin
      pend     <= 1'b1;
      pend_val <= clr_req;
    end
  end

  // R7
  clr_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_active != $past(clr_active)) |-> $past(tick));

endmodule

// File: rtl/dds_aux_accum.sv
module dds_aux_accum
  import dds_core_pkg::*;
#(
  parameter int AUX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  aux_mode_e        mode,
  input  logic             clr,
  input  logic             tick,
  input  logic [AUX_W-1:0] step,
  input  logic [AUX_W-1:0] limit,
  input  logic [AUX_W-1:0] num,
  input  logic [AUX_W-1:0] den,
  output logic [AUX_W-1:0] aux_val,
  output logic             carry
);
  localparam int EW = AUX_W + 1;

  // Saturating ramp step
  function automatic logic [AUX_W-1:0] ramp_next(input logic [AUX_W-1:0] cur,
                                                 input logic [AUX_W-1:0] inc,
                                                 input logic [AUX_W-1:0] ceil);
    logic [EW-1:0] s;
    s = {1'b0, cur} + {1'b0, inc};
    return (s >= {1'b0, ceil}) ? ceil : s[AUX_W-1:0];
  endfunction

  // Fractional counter sum, one bit wider
  function automatic logic [EW-1:0] frac_sum(input logic [AUX_W-1:0] cur,
                                             input logic [AUX_W-1:0] inc);
    return {1'b0, cur} + {1'b0, inc};
  endfunction

  logic [EW-1:0] msum;
  logic [EW-1:0] mwrap;
  logic          is_sweep;
  logic          is_mod;

  assign is_sweep = (mode == AUX_SWEEP);
  assign is_mod   = (mode == AUX_MOD);
  assign msum     = frac_sum(aux_val, num);
  assign mwrap    = msum - {1'b0, den};
  assign carry    = is_mod && !clr && (msum >= {1'b0, den});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 aux_val <= '0;
    else if (clr)               aux_val <= '0;
    else if (is_sweep && tick)  aux_val <= ramp_next(aux_val, step, limit);
    else if (is_mod)            aux_val <= carry ? mwrap[AUX_W-1:0] : msum[AUX_W-1:0];
  end

  // R4
  sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sweep && !clr && !tick) |=> $stable(aux_val));
  // R4
  sweep_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sweep && !clr && aux_val <= limit) |=> (aux_val <= $past(limit)));
  // R5
  mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mod && !clr && num < den && aux_val < den) |=> (aux_val < $past(den)));
  // R7
  aux_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (aux_val == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AUX_IDLE && !clr) |=> $stable(aux_val));

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] ftw,
  input  logic [PW-1:0] aux_add,
  input  logic          carry_in,
  input  logic [PW-1:0] pow,
  input  logic          lat_unmatched,
  output logic [PW-1:0] phase_out
);
  function automatic logic [PW-1:0] step_sum(input logic [PW-1:0] a,
                                             input logic [PW-1:0] f,
                                             input logic [PW-1:0] x,
                                             input logic          c);
    return a + f + x + PW'(c);
  endfunction

  logic [PW-1:0] acc;
  logic [PW-1:0] pow_q;
  logic [PW-1:0] pow_sel;

  assign pow_sel = lat_unmatched ? pow : pow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      pow_q     <= '0;
      phase_out <= '0;
    end else begin
      acc       <= clr ? '0 : step_sum(acc, ftw, aux_add, carry_in);
      pow_q     <= pow;
      phase_out <= acc + pow_sel;
    end
  end

  // R3
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
  // R9
  offset_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_unmatched) |=> (phase_out == $past(acc) + $past(pow_q)));

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_core_pkg::*;
#(
  parameter int PW       = 32,
  parameter int AUX_W    = 32,
  parameter int PROF_W   = 3,
  parameter int SYNC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_strobe,
  input  logic              sweep_en,
  input  logic              modulus_en,
  input  logic              dsw_en,
  input  logic              prof_from_int,
  input  logic [PROF_W-1:0] prof_int,
  input  logic [PROF_W-1:0] prof_pins,
  input  logic              clr_phase,
  input  logic              clr_aux,
  input  logic              lat_unmatched,
  input  logic [PW-1:0]     ftw,
  input  logic [PW-1:0]     pow,
  input  logic [AUX_W-1:0]  sweep_step,
  input  logic [AUX_W-1:0]  sweep_limit,
  input  logic [AUX_W-1:0]  mod_num,
  input  logic [AUX_W-1:0]  mod_den,
  output logic [PW-1:0]     phase_out,
  output logic              sync_tick,
  output logic [PROF_W-1:0] active_prof
);
  aux_mode_e         mode;
  logic [PROF_W-1:0] prof_q;
  logic              prof_chg;
  logic              aux_clr;
  logic [AUX_W-1:0]  aux_val;
  logic              aux_carry;
  logic [PW-1:0]     aux_add;

  assign mode        = pick_aux_mode(sweep_en, modulus_en, dsw_en);
  assign active_prof = prof_from_int ? prof_int : prof_pins;
  assign prof_chg    = (active_prof != prof_q);
  assign aux_add     = (mode == AUX_SWEEP) ? PW'(aux_val) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prof_q <= '0;
    else        prof_q <= active_prof;
  end

  dds_sync_div #(.SYNC_DIV(SYNC_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(sync_tick)
  );

  dds_aux_clr_sync u_clr (
    .clk(clk), .rst_n(rst_n), .upd(upd_strobe), .prof_chg(prof_chg),
    .tick(sync_tick), .clr_req(clr_aux), .clr_active(aux_clr)
  );

  dds_aux_accum #(.AUX_W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clr(aux_clr), .tick(sync_tick),
    .step(sweep_step), .limit(sweep_limit), .num(mod_num), .den(mod_den),
    .aux_val(aux_val), .carry(aux_carry)
  );

  dds_phase_accum #(.PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(clr_phase), .ftw(ftw), .aux_add(aux_add),
    .carry_in(aux_carry), .pow(pow), .lat_unmatched(lat_unmatched),
    .phase_out(phase_out)
  );

  // R5
  carry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_carry |-> (mode == AUX_MOD));
  // R6
  mod_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweep_en) |-> (!aux_carry && aux_add == '0));

endmodule

// File: tb/tb_dds_phase_core.sv
module tb_dds_phase_core;
  localparam int CLK_PERIOD = 10;
  localparam longint M = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_strobe = 0, sweep_en = 0, modulus_en = 0, dsw_en = 0, prof_from_int = 0;
  logic [2:0] prof_int = 0, prof_pins = 0;
  logic clr_phase = 0, clr_aux = 0, lat_unmatched = 0;
  logic [31:0] ftw = 0, pow = 0, sweep_step = 0, sweep_limit = 0, mod_num = 0, mod_den = 1;
  logic [31:0] phase_out;
  logic        sync_tick;
  logic [2:0]  active_prof;

  int n_run = 0, n_fail = 0;

  // behavioural reference state
  longint m_acc = 0, m_aux = 0, m_out = 0, m_powq = 0;
  int m_div = 0;
  bit m_clrq = 0, m_pend = 0, m_pendv = 0;
  int m_profq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_phase_core dut (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .sweep_en(sweep_en),
    .modulus_en(modulus_en), .dsw_en(dsw_en), .prof_from_int(prof_from_int),
    .prof_int(prof_int), .prof_pins(prof_pins), .clr_phase(clr_phase),
    .clr_aux(clr_aux), .lat_unmatched(lat_unmatched), .ftw(ftw), .pow(pow),
    .sweep_step(sweep_step), .sweep_limit(sweep_limit), .mod_num(mod_num),
    .mod_den(mod_den), .phase_out(phase_out), .sync_tick(sync_tick),
    .active_prof(active_prof)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sel_prof();
    return prof_from_int ? int'(prof_int) : int'(prof_pins);
  endfunction

  // one posedge worth of reference behaviour, using the inputs now applied
  task automatic model_step();
    bit tick, ev, sw, md, cy;
    longint sum, nacc, naux, nout;
    tick = (m_div == 3);
    ev   = upd_strobe || (sel_prof() != m_profq);
    sw   = sweep_en && !modulus_en && !dsw_en;
    md   = sweep_en && modulus_en && !dsw_en;
    sum  = m_aux + longint'(mod_num);
    cy   = md && !m_clrq && (sum >= longint'(mod_den));
    nout = (m_acc + (lat_unmatched ? longint'(pow) : m_powq)) & M;
    nacc = clr_phase ? 0 : (m_acc + longint'(ftw) + (sw ? m_aux : 0) + (cy ? 1 : 0)) & M;
    if (m_clrq) naux = 0;
    else if (sw && tick)
      naux = (m_aux + longint'(sweep_step) >= longint'(sweep_limit)) ? longint'(sweep_limit)
                                                                     : m_aux + longint'(sweep_step);
    else if (md) naux = cy ? (sum - longint'(mod_den)) & M : sum & M;
    else naux = m_aux;
    if (tick && (ev || m_pend)) begin
      m_clrq = ev ? clr_aux : m_pendv;
      m_pend = 0;
    end else if (ev) begin
      m_pend = 1;
      m_pendv = clr_aux;
    end
    m_profq = sel_prof();
    m_powq  = longint'(pow);
    m_div   = (m_div + 1) % 4;
    m_acc = nacc; m_aux = naux; m_out = nout;
  endtask

  task automatic cyc(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      upd_strobe = 0;
      check(req, "phase_out", longint'(phase_out), m_out);
      check(req, "sync_tick", longint'(sync_tick), (m_div == 3) ? 1 : 0);
      check(req, "active_prof", longint'(active_prof), longint'(sel_prof()));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "phase_out in reset", longint'(phase_out), 0);
    check("R1", "sync_tick in reset", longint'(sync_tick), 0);
    rst_n = 1;
    cyc("R11", 8);
    // R2 plain accumulation and wrap
    ftw = 32'h0123_4567;
    cyc("R2", 16);
    ftw = 32'hF000_0001;
    cyc("R2", 10);
    // R9 offset latency, both settings
    ftw = 32'h10;
    for (int k = 0; k < 8; k++) begin pow = 32'h1000 * (k + 1); cyc("R9", 1); end
    lat_unmatched = 1;
    for (int k = 0; k < 8; k++) begin pow = 32'h7000 + 32'h333 * k; cyc("R9", 1); end
    lat_unmatched = 0; pow = 0;
    cyc("R9", 2);
    // R3 phase clear
    clr_phase = 1;
    cyc("R3", 6);
    clr_phase = 0;
    cyc("R3", 4);
    // R4 sweep rises per tick and saturates
    ftw = 32'h100; sweep_en = 1; sweep_step = 32'h100; sweep_limit = 32'h500;
    cyc("R4", 40);
    // R7 request without event is not taken
    clr_aux = 1;
    cyc("R7", 8);
    upd_strobe = 1;
    cyc("R7", 10);
    clr_aux = 0; upd_strobe = 1;
    cyc("R7", 12);
    // R8 profile source and profile change as sample event
    clr_aux = 1; prof_pins = 3'd2;
    cyc("R8", 8);
    clr_aux = 0; prof_from_int = 1; prof_int = 3'd5;
    cyc("R8", 8);
    prof_from_int = 0;
    cyc("R8", 6);
    // R5 modulus: clear aux first, then 3/7
    clr_aux = 1; upd_strobe = 1;
    cyc("R5", 6);
    modulus_en = 1; mod_num = 3; mod_den = 7; clr_aux = 0; upd_strobe = 1;
    cyc("R5", 30);
    // R6 modulus bit without enable
    sweep_en = 0;
    cyc("R6", 10);
    // R10 direct switch bypass in sweep and modulus roles
    sweep_en = 1; dsw_en = 1;
    cyc("R10", 10);
    modulus_en = 0;
    cyc("R10", 10);
    dsw_en = 0;
    cyc("R4", 12);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule